// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for each beat of a four-beat burst inside a synchronous memory. A start address is captured on a rising clock edge whenever either of two address strobes is high: one strobe is driven by a processor and the other by a memory controller. Each later clock edge on which `advance` is high moves the burst to its next beat. The two low-order address bits follow a linear or an interleaved order, chosen by a static mode pin. The upper address bits keep the value that was captured.

The block holds the captured start address and a two-bit beat count. The current address is derived from these two registers. A memory core can place this block in its address path: the first access takes the strobed address, and the three later beats each take one cycle, giving a 3-1-1-1 pattern. The block has no data path, so all pins are plain control and status signals with no handshake. Storage, chip-enable decoding and output pipelining belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `addr_out` is 0, `beat_idx` is 0 and `last_beat` is 0.
- R2: A rising edge with `strobe_cpu` high captures `addr_in`. From the next cycle, `addr_out` equals the captured address and `beat_idx` is 0.
- R3: A rising edge with `strobe_ctl` high and `strobe_cpu` low also captures `addr_in`, with the same result as R2.
- R4: When both strobes are high on the same edge, the processor strobe takes priority and exactly one capture takes place, with the same result as R2. A strobe on any edge overrides `advance` on that edge.
- R5: A rising edge with `advance` high and both strobes low increments `beat_idx` modulo 4. After four such advances, the burst is back at beat 0 and at the captured address.
- R6: With `order_sel` = 0 (linear), the low two bits of `addr_out` are (captured low bits + `beat_idx`) mod 4. No carry goes into bit 2 or above.
- R7: With `order_sel` = 1 (interleaved), the low two bits of `addr_out` are the captured low bits XOR `beat_idx`. `order_sel` acts combinationally on the current beat.
- R8: A rising edge with both strobes low and `advance` low leaves `beat_idx` unchanged and leaves the captured address unchanged.
- R9: Bits `ADDR_W-1:2` of `addr_out` equal those of the last captured address throughout the burst.
- R10: `last_beat` is 1 exactly when `beat_idx` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor address strobe, highest priority |
| strobe_ctl | input | 1 | Controller address strobe |
| advance | input | 1 | Move to the next beat |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_in | input | ADDR_W | Start address that is captured by a strobe |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Position within the burst, 0 to 3 |
| last_beat | output | 1 | High on the fourth beat |

## Verification
A wrong beat count appears on `beat_idx` and in the low address bits on the cycle right after the faulty edge, so it is caught at once. A mapping fault can stay hidden while the beat count is 0. It shows up on the first advance in the affected order. A wrong captured address appears in the upper bits of `addr_out` on the cycle after the strobe and stays wrong until the next capture. The bench compares every cycle against its own model, so a fault of any of these kinds is reported within one cycle of the stimulus that exposes it.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Which strobe won the capture on this edge
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CPU  = 2'd1,
    LD_CTL  = 2'd2
  } load_e;

  // Beat ordering modes
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_cpu,
  input  logic strobe_ctl,
  input  logic advance,
  output logic do_load,
  output logic do_step
);
  load_e kind;

  always_comb begin
    if (strobe_cpu)      kind = LD_CPU;
    else if (strobe_ctl) kind = LD_CTL;
    else                 kind = LD_NONE;
  end

  assign do_load = (kind != LD_NONE);
  assign do_step = advance && (kind == LD_NONE);

  // R4
  load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_load && do_step));

  // R4
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu || strobe_ctl) |-> !do_step);
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)       beat <= '0;
    else if (do_load) beat <= '0;
    else if (do_step) beat <= beat + 1'b1;
  end

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> beat == BEAT_W'($past(beat) + 1'b1));

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_step && !do_load) |=> $stable(beat));

  // R2
  beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> beat == '0);
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)       base <= '0;
    else if (do_load) base <= addr_in;
  end

  // R9
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(base));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low_out
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // Linear order: modular sum, the carry out is dropped
  assign lin_lo = start_lo + beat;

  // Interleaved order: each bit toggles on its own beat bit
  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_lo[i] = start_lo[i] ^ beat[i];
  end

  assign low_out = (order == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx,
  output logic              last_beat
);
  localparam int BEAT_W = 2;
  localparam int BURST_LEN = 1 << BEAT_W;

  logic              do_load;
  logic              do_step;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low_bits;
  order_e            order;

  assign order = order_e'(order_sel);

  burst_load_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .do_load    (do_load),
    .do_step    (do_step)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_load (do_load),
    .do_step (do_step),
    .beat    (beat)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_load (do_load),
    .addr_in (addr_in),
    .base    (base)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo (base[BEAT_W-1:0]),
    .beat     (beat),
    .order    (order),
    .low_out  (low_bits)
  );

  assign addr_out  = {base[ADDR_W-1:BEAT_W], low_bits};
  assign beat_idx  = beat;
  assign last_beat = (beat == BEAT_W'(BURST_LEN - 1));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu || strobe_ctl) |=> addr_out == $past(addr_in));

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_cpu || strobe_ctl) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !strobe_cpu && !strobe_ctl && !order_sel) ##1 !order_sel
      |-> addr_out[1:0] == 2'($past(addr_out[1:0]) + 1'b1));

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !strobe_cpu && !strobe_ctl)
      |=> (!$stable(order_sel) || $stable(addr_out)));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe_cpu = 1'b0;
  logic              strobe_ctl = 1'b0;
  logic              advance = 1'b0;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [1:0]        beat_idx;
  logic              last_beat;

  int n_cmp = 0;
  int n_bad = 0;

  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_beat = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .beat_idx   (beat_idx),
    .last_beat  (last_beat)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [1:0] k,
                                                 input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ k) : 2'(b[1:0] + k);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string req);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr(m_base, m_beat, order_sel);
    n_cmp++;
    if (addr_out !== ea || beat_idx !== m_beat || last_beat !== (m_beat == 2'd3)) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d last=%b expected addr=%h beat=%0d last=%b",
               req, addr_out, beat_idx, last_beat, ea, m_beat, (m_beat == 2'd3));
    end
  endtask

  // Apply inputs, take one edge, update the model, check
  task automatic cyc(input logic sp, input logic sc, input logic adv,
                     input logic [ADDR_W-1:0] a, input logic md, input string req);
    strobe_cpu = sp; strobe_ctl = sc; advance = adv; addr_in = a; order_sel = md;
    @(posedge clk);
    #1;
    if (sp || sc) begin
      m_base = a; m_beat = 2'd0;
    end else if (adv) begin
      m_beat = m_beat + 2'd1;
    end
    check(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset");

    // R2: processor strobe, then linear walk with wrap (R5, R6, R9, R10)
    cyc(1, 0, 0, 16'hABCE, 0, "R2 cpu load");
    cyc(0, 0, 1, 16'h0000, 0, "R6 linear beat1");
    cyc(0, 0, 1, 16'h0000, 0, "R6 linear beat2 no carry R9");
    cyc(0, 0, 1, 16'h0000, 0, "R10 linear beat3 last");
    cyc(0, 0, 1, 16'h0000, 0, "R5 wrap to start");
    // R8: hold
    cyc(0, 0, 0, 16'hFFFF, 0, "R8 hold");
    cyc(0, 0, 0, 16'h1234, 0, "R8 hold again");

    // R3: controller strobe, interleaved walk (R7)
    cyc(0, 1, 0, 16'h5551, 1, "R3 ctl load");
    cyc(0, 0, 1, 16'h0000, 1, "R7 ilv beat1");
    cyc(0, 0, 1, 16'h0000, 1, "R7 ilv beat2");
    cyc(0, 0, 1, 16'h0000, 1, "R7 ilv beat3 R10");
    // R7: order_sel acts combinationally on the current beat
    cyc(0, 0, 0, 16'h0000, 0, "R7 mode switch to linear");

    // R4: both strobes, and strobe with advance
    cyc(1, 1, 1, 16'h7F03, 0, "R4 both strobes");
    cyc(0, 0, 1, 16'h0000, 0, "R4 step after load");
    cyc(0, 1, 1, 16'h8002, 1, "R4 strobe beats advance");

    for (int i = 0; i < 3000; i++) begin
      logic sp, sc, adv, md;
      logic [ADDR_W-1:0] a;
      sp  = ($urandom % 8) == 0;
      sc  = ($urandom % 8) == 0;
      adv = ($urandom % 3) != 0;
      md  = ($urandom % 16) == 0 ? ~order_sel : order_sel;
      a   = ADDR_W'($urandom);
      cyc(sp, sc, adv, a, md, "R2-R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule